// File: doc/BRIEF.md
# MSB-Guarded Magnitude Comparator

This block decides whether one unsigned operand is strictly greater than another, while keeping the lower-order part of its datapath quiet whenever that part cannot change the answer. The top bit of each operand bypasses all storage and feeds the decision logic directly. The remaining lower bits of each operand are captured in enable-controlled holding registers. These registers load only when the two top bits agree. When the top bits disagree, the answer is simply the top bit of operand A, and the lower path keeps its old contents, so none of its nodes switch.

A transaction is offered by raising the input strobe together with both operands. One clock later the result appears with a one-cycle output-valid pulse. A free-running flip counter adds up how many lower-path register bits changed on each load. The bench uses it to show at the ports that the guarded path stays still. Operand width is a parameter (minimum 2, default 16). Flop enables implement the guarding, so no clock-gating cells or latches are used.

Top module: `msb_guard_cmp`

## Requirements
- R1: One cycle after a strobed transaction, `gt_out` is 1 exactly when `opd_a` > `opd_b` as unsigned numbers of width W.
- R2: `out_vld` is high in the cycle after each cycle in which `in_vld` is high, and low in the cycle after each cycle in which `in_vld` is low.
- R3: When bit W-1 of `opd_a` and bit W-1 of `opd_b` differ, the result equals bit W-1 of `opd_a`, whatever the lower W-1 bits are.
- R4: When the top bits differ, the lower-bit holding registers keep their contents, and `toggle_cnt` does not change at that clock edge.
- R5: When the top bits match on a strobed cycle, both holding registers load bits W-2..0 of their operand. `toggle_cnt` then grows by the number of lower bits that differ from the previously held values, summed over A and B.
- R6: In a cycle without `in_vld`, no holding register changes, `toggle_cnt` stays constant, and `gt_out` holds its last value.
- R7: After reset, `out_vld`, `gt_out` and `toggle_cnt` are 0, and both holding registers contain all zeros.
- R8: Equal operands give `gt_out` = 0, including the all-zero and all-one patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operand strobe |
| opd_a | input | W | Unsigned operand A |
| opd_b | input | W | Unsigned operand B |
| gt_out | output | 1 | 1 when A > B for the last strobed pair |
| out_vld | output | 1 | Result-valid pulse, one cycle after the strobe |
| toggle_cnt | output | CNT_W | Running count of lower-path register bit flips |

## Verification
Held lower bits that are wrong appear at the ports in two ways. The next matching-top-bit transaction gives a flip count delta that differs from the one predicted from the last operands actually loaded, and a near tie between operands can give the wrong `gt_out`. Both show one cycle after that strobe. A guard that leaks, loading while the top bits differ, changes `toggle_cnt` at the very edge of that transaction. A stuck decision register shows as a wrong result or valid pulse on the next strobe.

// File: rtl/msb_guard_pkg.sv
package msb_guard_pkg;

  // number of positions that differ between two words
  function automatic int unsigned flip_count(input logic [63:0] x, input logic [63:0] y);
    flip_count = $countones(x ^ y);
  endfunction

endpackage

// File: rtl/mg_rst_sync.sv
module mg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/mg_guard_reg.sv
module mg_guard_reg #(
  parameter int unsigned DW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mg_flip_meter.sv
module mg_flip_meter
  import msb_guard_pkg::*;
#(
  parameter int unsigned DW    = 15,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DW-1:0]    cur_a,
  input  logic [DW-1:0]    nxt_a,
  input  logic [DW-1:0]    cur_b,
  input  logic [DW-1:0]    nxt_b,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] delta;

  always_comb begin
    delta   = CNT_W'(flip_count(64'(cur_a), 64'(nxt_a)) + flip_count(64'(cur_b), 64'(nxt_b)));
    cnt_nxt = cnt;
    if (load_en) cnt_nxt = cnt + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/msb_guard_cmp.sv
module msb_guard_cmp #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [W-1:0]     opd_a,
  input  logic [W-1:0]     opd_b,
  output logic             gt_out,
  output logic             out_vld,
  output logic [CNT_W-1:0] toggle_cnt
);
  localparam int unsigned LW    = W - 1;
  localparam int unsigned N_OPD = 2;

  logic                      rst_sync_n;
  logic                      top_eq;
  logic                      lo_load;
  logic [N_OPD-1:0][LW-1:0]  lo_d;
  logic [N_OPD-1:0][LW-1:0]  lo_q;
  logic                      lo_gt;

  // decision stage registers
  logic vld_q, vld_nxt;
  logic eq_q, eq_nxt;
  logic amsb_q, amsb_nxt;

  mg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign top_eq  = (opd_a[W-1] == opd_b[W-1]);
  assign lo_load = in_vld & top_eq;
  assign lo_d[0] = opd_a[LW-1:0];
  assign lo_d[1] = opd_b[LW-1:0];

  for (genvar g = 0; g < N_OPD; g++) begin : g_hold
    mg_guard_reg #(.DW(LW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load_en (lo_load),
      .d       (lo_d[g]),
      .q       (lo_q[g])
    );
  end

  assign lo_gt = (lo_q[0] > lo_q[1]);

  mg_flip_meter #(.DW(LW), .CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (lo_load),
    .cur_a   (lo_q[0]),
    .nxt_a   (lo_d[0]),
    .cur_b   (lo_q[1]),
    .nxt_b   (lo_d[1]),
    .cnt     (toggle_cnt)
  );

  always_comb begin
    vld_nxt  = in_vld;
    eq_nxt   = eq_q;
    amsb_nxt = amsb_q;
    if (in_vld) begin
      eq_nxt   = top_eq;
      amsb_nxt = opd_a[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      eq_q   <= 1'b0;
      amsb_q <= 1'b0;
    end else begin
      vld_q  <= vld_nxt;
      eq_q   <= eq_nxt;
      amsb_q <= amsb_nxt;
    end
  end

  assign out_vld = vld_q;
  assign gt_out  = eq_q ? lo_gt : amsb_q;
endmodule

// File: rtl/msb_guard_cmp_chk.sv
module msb_guard_cmp_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [W-1:0]     opd_a,
  input logic [W-1:0]     opd_b,
  input logic             gt_out,
  input logic             out_vld,
  input logic [CNT_W-1:0] toggle_cnt
);
  // R1
  gt_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (gt_out == ($past(opd_a) > $past(opd_b))));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R3
  top_decides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (opd_a[W-1] != opd_b[W-1])) |=> (gt_out == $past(opd_a[W-1])));

  // R4
  guard_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (opd_a[W-1] != opd_b[W-1])) |=> $stable(toggle_cnt));

  // R6
  idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(toggle_cnt) && $stable(gt_out)));

  // R8
  tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (opd_a == opd_b)) |=> !gt_out);
endmodule

bind msb_guard_cmp msb_guard_cmp_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_vld     (in_vld),
  .opd_a      (opd_a),
  .opd_b      (opd_b),
  .gt_out     (gt_out),
  .out_vld    (out_vld),
  .toggle_cnt (toggle_cnt)
);

// File: tb/test_msb_guard_cmp.sv
`timescale 1ns/1ps
module test_msb_guard_cmp;
  localparam int unsigned W     = 16;
  localparam int unsigned LW    = W - 1;
  localparam int unsigned CNT_W = 32;

  logic             clk;
  logic             rst_n;
  logic             in_vld;
  logic [W-1:0]     opd_a;
  logic [W-1:0]     opd_b;
  logic             gt_out;
  logic             out_vld;
  logic [CNT_W-1:0] toggle_cnt;

  int unsigned n_chk;
  int unsigned n_err;
  bit          done;

  // bench model of the held lower bits and the flip count
  logic [LW-1:0]    m_lo_a;
  logic [LW-1:0]    m_lo_b;
  logic [CNT_W-1:0] m_cnt;
  logic             m_gt;

  msb_guard_cmp #(.W(W), .CNT_W(CNT_W)) i_msb_guard_cmp (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opd_a(opd_a), .opd_b(opd_b),
    .gt_out(gt_out), .out_vld(out_vld), .toggle_cnt(toggle_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one strobed transaction, result sampled one clock later
  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [CNT_W-1:0] d;
    @(negedge clk);
    in_vld = 1'b1; opd_a = a; opd_b = b;
    m_gt = (a > b);
    if (a[W-1] == b[W-1]) begin
      d = CNT_W'($countones(a[LW-1:0] ^ m_lo_a) + $countones(b[LW-1:0] ^ m_lo_b));
      m_cnt  = m_cnt + d;
      m_lo_a = a[LW-1:0];
      m_lo_b = b[LW-1:0];
    end
    @(negedge clk);
    check(req, "out_vld", 64'(out_vld), 64'd1);
    check(req, "gt_out", 64'(gt_out), 64'(m_gt));
    check(req, "toggle_cnt", 64'(toggle_cnt), 64'(m_cnt));
    in_vld = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_vld = 1'b0; opd_a = '0; opd_b = '0;
    m_lo_a = '0; m_lo_b = '0; m_cnt = '0; m_gt = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", "out_vld in reset", 64'(out_vld), 64'd0);
    check("R7", "gt_out in reset", 64'(gt_out), 64'd0);
    check("R7", "toggle_cnt in reset", 64'(toggle_cnt), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7", "toggle_cnt after release", 64'(toggle_cnt), 64'd0);
    // held lower bits are zero: first load counts the ones in the operands
    do_op(16'h0003, 16'h0001, "R7");
  endtask

  task automatic t_same_top;
    do_op(16'h1234, 16'h1233, "R1");
    do_op(16'h1233, 16'h1234, "R1");
    do_op(16'h8001, 16'h8000, "R5");
    do_op(16'hFFFE, 16'hFFFF, "R5");
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = {a[W-1], LW'($urandom)};
      do_op(a, b, "R5");
    end
  endtask

  task automatic t_top_differs;
    do_op(16'h8000, 16'h7FFF, "R3");
    do_op(16'h7FFF, 16'h8000, "R3");
    do_op(16'h0000, 16'hFFFF, "R4");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = {~a[W-1], LW'($urandom)};
      do_op(a, b, "R4");
    end
    // next matched load measures flips against the last loaded values
    do_op(16'h0F0F, 16'h00F0, "R4");
  endtask

  task automatic t_idle;
    logic [CNT_W-1:0] c0;
    logic             g0;
    do_op(16'h4444, 16'h4443, "R6");
    c0 = toggle_cnt; g0 = gt_out;
    @(negedge clk);
    opd_a = 16'h0000; opd_b = 16'h3FFF;
    repeat (5) @(negedge clk);
    check("R6", "out_vld idle", 64'(out_vld), 64'd0);
    check("R6", "toggle_cnt idle", 64'(toggle_cnt), 64'(c0));
    check("R6", "gt_out idle", 64'(gt_out), 64'(g0));
    do_op(16'h4444, 16'h4443, "R6");
  endtask

  task automatic t_ties;
    do_op(16'h0000, 16'h0000, "R8");
    do_op(16'hFFFF, 16'hFFFF, "R8");
    do_op(16'h5A5A, 16'h5A5A, "R8");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_vld = 1'b1; opd_a = 16'h0002; opd_b = 16'h0001;
    m_cnt = m_cnt + CNT_W'($countones(15'h0002 ^ m_lo_a) + $countones(15'h0001 ^ m_lo_b));
    m_lo_a = 15'h0002; m_lo_b = 15'h0001;
    @(negedge clk);
    check("R2", "out_vld first", 64'(out_vld), 64'd1);
    check("R1", "gt_out first", 64'(gt_out), 64'd1);
    opd_a = 16'h8000; opd_b = 16'h0001;
    @(negedge clk);
    check("R2", "out_vld second", 64'(out_vld), 64'd1);
    check("R3", "gt_out second", 64'(gt_out), 64'd1);
    check("R4", "toggle_cnt second", 64'(toggle_cnt), 64'(m_cnt));
    in_vld = 1'b0;
    @(negedge clk);
    check("R2", "out_vld drop", 64'(out_vld), 64'd0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    t_reset();
    t_same_top();
    t_top_differs();
    t_idle();
    t_ties();
    t_back_to_back();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule